// File: doc/BRIEF.md
# Bouncing Bar Pixel Pattern Generator

This block colours each pixel of a 640 by 480 visible frame. A separate sync timing generator supplies the current column, the current row and a flag that marks active video. The block returns 4-bit red, green and blue values for that pixel with no register delay. Two shapes are drawn on a black background. The first is a fixed green vertical stripe that runs the full height of the frame. The second is a red bar, six columns wide, that spans a fixed band of rows.

The bar moves. A slow step timer fires once every `TICK_CYCLES` clocks. The default is 50,000,000, which is half a second at 100 MHz. On each step the bar shifts one column in its current direction. A single direction bit turns the bar around when it reaches either side of the frame, so the bar sweeps back and forth and always stays inside the visible area. Reset puts the bar at the left side, heading right. Sync generation and the physical display connector belong to other blocks.

Top module: `bounce_bar_pattern`

## Requirements
- R1: While reset is asserted, and on release, the bar occupies columns 0 to 5 and its direction is rightward.
- R2: When `vid_on` is 0, all three colour outputs are 0, whatever the coordinates.
- R3: During active video, a pixel in columns 32 to 35, on any row, that is not covered by the bar is green: green = 4'hF, red = 0, blue = 0.
- R4: During active video, a pixel is red (red = 4'hF, green = 0, blue = 0) exactly when its column lies in [L, L+5] and its row lies in [200, 250]. L is the bar's current left column.
- R5: Where the bar and the stripe overlap, the pixel is red.
- R6: During active video, every pixel outside both the stripe and the bar is black.
- R7: The bar moves by exactly one column on every step and holds still between steps. The first step comes `TICK_CYCLES` clock edges after reset is released, and each later step comes `TICK_CYCLES` edges after the one before it.
- R8: A step taken while moving right with L = 634 (right column 639) reverses the direction to leftward and sets L to 633.
- R9: A step taken while moving left with L = 0 reverses the direction to rightward and sets L to 1.
- R10: L never exceeds 634, so the bar never leaves the visible area.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| px_x | input | 10 | Current pixel column |
| px_y | input | 9 | Current pixel row |
| vid_on | input | 1 | High while the coordinates are in the visible area |
| red | output | 4 | Red intensity |
| grn | output | 4 | Green intensity |
| blu | output | 4 | Blue intensity |

## Verification
The bench uses a step period of four clocks, so the bar completes more than a full round trip. Every cycle, one pixel is placed relative to the bar's expected position:
- one column outside each bar edge, which separates off-by-one errors in the horizontal limits;
- on the bar's first and last columns;
- one row outside each vertical limit.

Probes at scattered coordinates, once with video on and once with it off, cover the stripe and the blanking. A full-row sweep, and stripe-edge probes at the top and bottom rows, show that the stripe's limits are right and that the bar has priority when it crosses the stripe. Dedicated probes fire at both turnarounds. They show that the bar reaches column 639 and reverses at that point, without stalling or wrapping.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb12_t;

  localparam rgb12_t COLOR_BLACK = '{r: 4'h0, g: 4'h0, b: 4'h0};
  localparam rgb12_t COLOR_RED   = '{r: 4'hF, g: 4'h0, b: 4'h0};
  localparam rgb12_t COLOR_GREEN = '{r: 4'h0, g: 4'hF, b: 4'h0};

  // Inclusive range test shared by all coordinate decoders.
  function automatic logic in_span(input int unsigned v,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Next left column and direction for one step of the bar.
  function automatic int unsigned next_left(input int unsigned left,
                                            input logic going_right,
                                            input int unsigned left_max);
    if (going_right) return (left == left_max) ? left - 1 : left + 1;
    else             return (left == 0)        ? 1        : left - 1;
  endfunction

endpackage

// File: rtl/bbp_step_timer.sv
module bbp_step_timer #(
  parameter int unsigned TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic step_tick
);
  localparam int unsigned CNT_W = (TICK_CYCLES < 2) ? 1 : $clog2(TICK_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (step_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  // R7: the counter stays within one step period
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R7: after a step the period restarts from zero
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (step_tick && TICK_CYCLES > 1) |=> (cnt_q == '0));

endmodule

// File: rtl/bbp_bar_tracker.sv
module bbp_bar_tracker
  import bbp_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned BAR_W    = 6,
  parameter int unsigned X_W      = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_tick,
  output logic [X_W-1:0] bar_left,
  output logic           bounce_right,
  output logic           bounce_left
);
  localparam int unsigned LEFT_MAX = H_ACTIVE - BAR_W;

  logic [X_W-1:0] left_q;
  logic           dir_right_q;

  assign bounce_right = step_tick &&  dir_right_q && (32'(left_q) == LEFT_MAX);
  assign bounce_left  = step_tick && !dir_right_q && (left_q == '0);
  assign bar_left     = left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q      <= '0;
      dir_right_q <= 1'b1;
    end else if (step_tick) begin
      left_q <= X_W'(next_left(32'(left_q), dir_right_q, LEFT_MAX));
      if (bounce_right)     dir_right_q <= 1'b0;
      else if (bounce_left) dir_right_q <= 1'b1;
    end
  end

  // R7: the bar holds still between steps
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(left_q));
  // R7: every step changes the position by one
  a_r7_moves: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> (left_q != $past(left_q)));
  // R8: right turnaround
  a_r8_turn_right: assert property (@(posedge clk) disable iff (rst)
    bounce_right |=> (!dir_right_q && 32'(left_q) == LEFT_MAX - 1));
  // R9: left turnaround
  a_r9_turn_left: assert property (@(posedge clk) disable iff (rst)
    bounce_left |=> (dir_right_q && left_q == X_W'(1)));
  // R10: bar stays inside the visible area
  a_r10_in_area: assert property (@(posedge clk) disable iff (rst)
    32'(left_q) <= LEFT_MAX);

endmodule

// File: rtl/bbp_pixel_shader.sv
module bbp_pixel_shader
  import bbp_pkg::*;
#(
  parameter int unsigned BAR_W     = 6,
  parameter int unsigned BAR_TOP   = 200,
  parameter int unsigned BAR_BOT   = 250,
  parameter int unsigned STRIPE_LO = 32,
  parameter int unsigned STRIPE_HI = 35,
  parameter int unsigned X_W       = 10,
  parameter int unsigned Y_W       = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [X_W-1:0] px_x,
  input  logic [Y_W-1:0] px_y,
  input  logic           vid_on,
  input  logic [X_W-1:0] bar_left,
  output rgb12_t         pix
);
  logic bar_hit;
  logic stripe_hit;

  assign bar_hit = in_span(32'(px_x), 32'(bar_left), 32'(bar_left) + BAR_W - 1)
                && in_span(32'(px_y), BAR_TOP, BAR_BOT);
  assign stripe_hit = in_span(32'(px_x), STRIPE_LO, STRIPE_HI);

  always_comb begin
    if (!vid_on)         pix = COLOR_BLACK;
    else if (bar_hit)    pix = COLOR_RED;
    else if (stripe_hit) pix = COLOR_GREEN;
    else                 pix = COLOR_BLACK;
  end

  // R2: nothing is lit outside active video
  a_r2_blank: assert property (@(posedge clk) disable iff (rst)
    !vid_on |-> (pix == COLOR_BLACK));
  // R5: the bar covers the stripe where both apply
  a_r5_bar_wins: assert property (@(posedge clk) disable iff (rst)
    (vid_on && bar_hit && stripe_hit) |-> (pix == COLOR_RED));
  // R6: at most one primary colour is ever lit
  a_r6_single_hue: assert property (@(posedge clk) disable iff (rst)
    $countones({pix.r != 0, pix.g != 0, pix.b != 0}) <= 1);

endmodule

// File: rtl/bounce_bar_pattern.sv
module bounce_bar_pattern
  import bbp_pkg::*;
#(
  parameter int unsigned H_ACTIVE    = 640,
  parameter int unsigned V_ACTIVE    = 480,
  parameter int unsigned BAR_W       = 6,
  parameter int unsigned BAR_TOP     = 200,
  parameter int unsigned BAR_BOT     = 250,
  parameter int unsigned STRIPE_LO   = 32,
  parameter int unsigned STRIPE_HI   = 35,
  parameter int unsigned TICK_CYCLES = 50_000_000,
  localparam int unsigned X_W        = $clog2(H_ACTIVE),
  localparam int unsigned Y_W        = $clog2(V_ACTIVE)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [X_W-1:0] px_x,
  input  logic [Y_W-1:0] px_y,
  input  logic           vid_on,
  output logic [3:0]     red,
  output logic [3:0]     grn,
  output logic [3:0]     blu
);
  logic           step_tick;
  logic [X_W-1:0] bar_left;
  logic           bounce_right;
  logic           bounce_left;
  rgb12_t         pix;

  bbp_step_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .step_tick(step_tick)
  );

  bbp_bar_tracker #(.H_ACTIVE(H_ACTIVE), .BAR_W(BAR_W), .X_W(X_W)) u_bar (
    .clk(clk), .rst(rst), .step_tick(step_tick), .bar_left(bar_left),
    .bounce_right(bounce_right), .bounce_left(bounce_left)
  );

  bbp_pixel_shader #(
    .BAR_W(BAR_W), .BAR_TOP(BAR_TOP), .BAR_BOT(BAR_BOT),
    .STRIPE_LO(STRIPE_LO), .STRIPE_HI(STRIPE_HI), .X_W(X_W), .Y_W(Y_W)
  ) u_shade (
    .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y), .vid_on(vid_on),
    .bar_left(bar_left), .pix(pix)
  );

  assign red = pix.r;
  assign grn = pix.g;
  assign blu = pix.b;

  // R1: the bar starts at the left side, heading right
  a_r1_reset_home: assert property (@(posedge clk)
    $fell(rst) |-> (bar_left == '0 && !bounce_left));
  // R8/R9: the two turnarounds never coincide
  a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bounce_right && bounce_left));

endmodule

// File: tb/bounce_bar_pattern_tb.sv
module bounce_bar_pattern_tb;
  localparam int TICK     = 4;
  localparam int LEFT_MAX = 634;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] px_x = '0;
  logic [8:0] px_y = '0;
  logic       vid_on = 1'b0;
  logic [3:0] red, grn, blu;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int  m_cnt  = 0;
  int  m_left = 0;
  bit  m_dir  = 1'b1;

  always #2 clk = ~clk;

  bounce_bar_pattern #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y), .vid_on(vid_on),
    .red(red), .grn(grn), .blu(blu)
  );

  // Reference position: one column per TICK edges, bounce at either side.
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_left <= 0; m_dir <= 1'b1;
    end else if (m_cnt == TICK - 1) begin
      m_cnt <= 0;
      if (m_dir && m_left == LEFT_MAX)  begin m_dir <= 1'b0; m_left <= LEFT_MAX - 1; end
      else if (!m_dir && m_left == 0)   begin m_dir <= 1'b1; m_left <= 1; end
      else if (m_dir)                   m_left <= m_left + 1;
      else                              m_left <= m_left - 1;
    end else begin
      m_cnt <= m_cnt + 1;
    end
  end

  function automatic logic [11:0] expect_pix(int x, int y, bit v, int left);
    if (!v) return 12'h000;
    if (x >= left && x < left + 6 && y >= 200 && y <= 250) return 12'hF00;
    if (x >= 32 && x <= 35) return 12'h0F0;
    return 12'h000;
  endfunction

  function automatic string auto_tag(int x, int y, bit v, int left);
    bit in_bar = (x >= left && x < left + 6 && y >= 200 && y <= 250);
    bit in_str = (x >= 32 && x <= 35);
    if (!v) return "R2";
    if (in_bar && in_str) return "R5";
    if (in_bar) return "R4";
    if (in_str) return "R3";
    return "R6";
  endfunction

  task automatic probe(int x, int y, bit v, string tag);
    @(negedge clk);
    px_x = 10'(x); px_y = 9'(y); vid_on = v;
    #1;
    n_checks++;
    if ({red, grn, blu} !== expect_pix(x, y, v, m_left)) begin
      n_fail++;
      $display("FAIL %s x=%0d y=%0d vid=%0b actual=%h expected=%h", tag, x, y, v,
               {red, grn, blu}, expect_pix(x, y, v, m_left));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: bar home position while reset is held
    repeat (3) @(posedge clk);
    probe(0, 200, 1'b1, "R1");
    probe(5, 250, 1'b1, "R1");
    probe(6, 225, 1'b1, "R1");
    probe(33, 100, 1'b1, "R3");
    probe(300, 100, 1'b0, "R2");
    @(negedge clk); rst = 1'b0;

    // R3: stripe limits at top and bottom rows
    for (int y = 0; y < 480; y += 479)
      for (int x = 30; x <= 37; x++) probe(x, y, 1'b1, (x < 32 || x > 35) ? "R6" : "R3");

    // Full-row sweep through the bar rows
    for (int x = 0; x < 640; x++) probe(x, 230, 1'b1, auto_tag(x, 230, 1'b1, m_left));

    // Bar-relative probes over more than a full round trip
    for (int k = 0; k < 6000; k++) begin
      int x, y; bit v; string t;
      v = 1'b1;
      if (!m_dir && m_left == LEFT_MAX - 1) begin x = 639; y = 225; t = "R8"; end
      else if (m_dir && m_left == 1)        begin x = 0;   y = 225; t = "R9"; end
      else if (m_left == LEFT_MAX)          begin x = 639; y = 200; t = "R10"; end
      else begin
        case (k % 8)
          0: begin x = (m_left > 0) ? m_left - 1 : m_left + 6; y = 200; t = "R7"; end
          1: begin x = m_left;     y = 250; t = "R4"; end
          2: begin x = m_left + 5; y = 225; t = "R4"; end
          3: begin x = (m_left + 6 < 640) ? m_left + 6 : 0; y = 200; t = "R7"; end
          4: begin x = m_left;     y = 199; t = "R4"; end
          5: begin x = m_left + 2; y = 251; t = "R4"; end
          6: begin x = (k * 37) % 640; y = (k * 13) % 480;
                   t = auto_tag(x, y, 1'b1, m_left); end
          default: begin x = (k * 53) % 640; y = (k * 7) % 480; v = 1'b0; t = "R2"; end
        endcase
      end
      probe(x, y, v, t);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule